// File: doc/BRIEF.md
# Stream Stall Timeout Monitor

This block watches one streaming output for backpressure stalls. A stall is a cycle in which the transfer still has data left, the source offers a beat, and the downstream consumer refuses it. While stalls continue, a programmable prescaler divides the clock into ticks, and a programmable limit counter counts those ticks. When the limit runs out, the block emits a single-cycle timeout event. A flag register elsewhere latches this event as the stream-timeout interrupt bit.

Any cycle that is not a stall ends the measurement: an accepted beat, no data left, no beat offered, or the enable cleared. The next stall starts again from the full programmed interval. The prescaler and limit values are captured when a measurement starts. Changing them during a measurement has no effect until the next one starts. Each stall yields at most one event, however long it lasts.

Top module: `stall_timeout_monitor`

## Requirements
- R1: While reset is low and after it is released, `tmo_event` is 0 until a timeout actually expires.
- R2: A stalled cycle is one where `tmo_en`, `xfer_pending` and `strm_valid` are 1 and `strm_ready` is 0. Any other cycle ends the current measurement, including a cycle in which only `xfer_pending` drops.
- R3: With prescaler value P and limit value T, `tmo_event` goes high in the cycle right after the (P+1)*(T+1)-th consecutive stalled clock edge.
- R4: `tmo_event` is a one-cycle pulse. At most one pulse occurs per unbroken stall, however long the stall lasts.
- R5: An accepted beat (`strm_valid` and `strm_ready` both 1) ends the measurement. A following stall needs the full (P+1)*(T+1) stalled edges again.
- R6: With `tmo_en` at 0 no event is produced. Clearing it during a stall discards the progress of that stall.
- R7: With `xfer_pending` at 0 no event is produced, whatever the stream handshake does.
- R8: Changing `cfg_prescale` or `cfg_limit` during a measurement does not change that measurement's interval. The new values apply from the next measurement.
- R9: With P=0 and T=0 the event follows the first stalled edge.
- R10: With `strm_valid` at 0 no event is produced, even while `strm_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_en | input | 1 | Timeout enable |
| cfg_prescale | input | PRESC_W (12) | Prescaler value P; the tick comes every P+1 stalled cycles |
| cfg_limit | input | LIMIT_W (12) | Limit value T; expiry after T+1 ticks |
| xfer_pending | input | 1 | Transfer still has data left |
| strm_valid | input | 1 | Source offers a beat |
| strm_ready | input | 1 | Consumer accepts a beat |
| tmo_event | output | 1 | One-cycle stream-timeout event |

## Verification
Every stalled edge is one counting step, and the event comes out of a register. So the pulse is due in the cycle that starts at the (P+1)*(T+1)-th stalled edge after the stimulus begins. For each stall it drives, the driver records the cycle stamp at which the pulse must appear. The monitor samples on the falling edge and compares each pulse it sees against the head of that queue, so an early or late pulse shows up as a mismatched stamp. After each scenario the bench also compares the number of pulses seen against the number expected. This catches spurious or repeated pulses in the cases where none should occur.

// File: rtl/stw_pkg.sv
// Shared widths and the measurement state encoding of the stall timeout monitor.
package stw_pkg;
    localparam int unsigned PRESC_W = 12;
    localparam int unsigned LIMIT_W = 12;

    typedef enum logic [1:0] {
        ARM_IDLE  = 2'd0,
        ARM_RUN   = 2'd1,
        ARM_SPENT = 2'd2
    } arm_state_e;
endpackage

// File: rtl/stw_reload_cnt.sv
// Reloading down-counter, used for both the prescaler and the limit stage.
// While rearm is high it tracks the configuration, so a step in that same
// cycle already counts. Outside rearm it uses a captured copy of the value.
// wrap is combinational: a step taken while the current count is zero.
// Assumes rearm is high for every cycle in which no measurement is running.
module stw_reload_cnt #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rearm,
    input  logic         step,
    input  logic [W-1:0] cfg_val,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] snap_q;
    logic [W-1:0] cur_val;

    // Current count: the live configuration while idle, else the running count.
    assign cur_val = rearm ? cfg_val : cnt_q;
    assign wrap    = step && (cur_val == '0);

    // Capture on re-arm, count down on each step, reload from the capture on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            snap_q <= '0;
        end else if (rearm) begin
            snap_q <= cfg_val;
            cnt_q  <= (step && cfg_val != '0) ? cfg_val - ONE : cfg_val;
        end else if (step) begin
            cnt_q  <= wrap ? snap_q : cnt_q - ONE;
        end
    end

    // The running count never exceeds the value captured at arm time.
    p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm |-> cnt_q <= snap_q);

    // Configuration changes are ignored while a measurement runs.
    p_snap_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm |=> $stable(snap_q));
endmodule

// File: rtl/stw_arm_ctrl.sv
// Measurement state: idle (re-arming), running, or spent after an event.
// A non-stalled cycle always returns to idle. Assumes expire can only be
// high while stall is high.
module stw_arm_ctrl
    import stw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall,
    input  logic       expire,
    output logic       rearm,
    output logic       step,
    output arm_state_e state
);
    arm_state_e state_q;
    arm_state_e state_d;

    assign state = state_q;
    assign rearm = (state_q == ARM_IDLE);
    assign step  = stall && (state_q != ARM_SPENT);

    // Next-state choice from the stall condition and the expiry.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ARM_IDLE:  if (stall) state_d = expire ? ARM_SPENT : ARM_RUN;
            ARM_RUN:   if (!stall) state_d = ARM_IDLE;
                       else if (expire) state_d = ARM_SPENT;
            ARM_SPENT: if (!stall) state_d = ARM_IDLE;
            default:   state_d = ARM_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    // Once spent, the stall must end before another count starts.
    p_spent_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_SPENT && stall) |=> state_q == ARM_SPENT);

    // Any non-stalled cycle re-arms from the full interval.
    p_release_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> state_q == ARM_IDLE);
endmodule

// File: rtl/stall_timeout_monitor.sv
// Backpressure timeout monitor. A prescaler and a limit counter measure an
// unbroken stall, and a registered one-cycle event is raised when the limit
// expires. Assumes the inputs are synchronous to clk.
module stall_timeout_monitor
    import stw_pkg::*;
#(
    parameter int unsigned PRESC_W = stw_pkg::PRESC_W,
    parameter int unsigned LIMIT_W = stw_pkg::LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tmo_en,
    input  logic [PRESC_W-1:0] cfg_prescale,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               xfer_pending,
    input  logic               strm_valid,
    input  logic               strm_ready,
    output logic               tmo_event
);
    logic       stall;
    logic       rearm;
    logic       step;
    logic       tick;
    logic       expire;
    logic       event_q;
    arm_state_e arm_state;

    // A stalled cycle: enabled, data left, beat offered, consumer refusing.
    assign stall = tmo_en && xfer_pending && strm_valid && !strm_ready;

    stw_arm_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .expire (expire),
        .rearm  (rearm),
        .step   (step),
        .state  (arm_state)
    );

    stw_reload_cnt #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .rearm   (rearm),
        .step    (step),
        .cfg_val (cfg_prescale),
        .wrap    (tick)
    );

    stw_reload_cnt #(.W(LIMIT_W)) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .rearm   (rearm),
        .step    (tick),
        .cfg_val (cfg_limit),
        .wrap    (expire)
    );

    // Register the expiry into the outgoing event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= 1'b0;
        else        event_q <= expire;
    end

    assign tmo_event = event_q;

    // The event is a single-cycle pulse.
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_event |=> !tmo_event);

    // An event only follows a stalled cycle, so enable, pending and valid gate it.
    p_event_needs_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> !tmo_event);

    // After an event the controller sits in the spent state while the stall lasts.
    p_event_spends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_event |-> arm_state == ARM_SPENT || !$past(stall) || arm_state == ARM_IDLE);
endmodule

// File: tb/stall_timeout_monitor_bench.sv
module stall_timeout_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tmo_en;
    logic [11:0] cfg_prescale;
    logic [11:0] cfg_limit;
    logic        xfer_pending;
    logic        strm_valid;
    logic        strm_ready;
    logic        tmo_event;

    always #5 clk = ~clk;

    stall_timeout_monitor u_stall_timeout_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmo_en       (tmo_en),
        .cfg_prescale (cfg_prescale),
        .cfg_limit    (cfg_limit),
        .xfer_pending (xfer_pending),
        .strm_valid   (strm_valid),
        .strm_ready   (strm_ready),
        .tmo_event    (tmo_event)
    );

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    int    ev_seen = 0;
    bit    finished = 1'b0;
    int    exp_cyc[$];
    string exp_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: each pulse is popped against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && tmo_event) begin
            ev_seen++;
            total++;
            if (exp_cyc.size() == 0) begin
                bad++;
                $display("FAIL R4: unexpected event at cycle %0d, expected none", cyc);
            end else begin
                int    e;
                string t;
                e = exp_cyc.pop_front();
                t = exp_tag.pop_front();
                if (cyc != e) begin
                    bad++;
                    $display("FAIL %s: event at cycle %0d, expected %0d", t, cyc, e);
                end
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        xfer_pending = 1'b0;
        strm_valid   = 1'b0;
        strm_ready   = 1'b0;
    endtask

    task automatic set_stall(input int p, input int t);
        cfg_prescale = p[11:0];
        cfg_limit    = t[11:0];
        tmo_en       = 1'b1;
        xfer_pending = 1'b1;
        strm_valid   = 1'b1;
        strm_ready   = 1'b0;
    endtask

    // Driver: push the expected pulse cycle for a stall starting now.
    task automatic expect_after(input int n, input string tag);
        exp_cyc.push_back(cyc + n);
        exp_tag.push_back(tag);
    endtask

    task automatic check_count(input int start, input int want, input string tag);
        total++;
        if (ev_seen - start != want) begin
            bad++;
            $display("FAIL %s: %0d events seen, expected %0d", tag, ev_seen - start, want);
        end
    endtask

    // One stall of len edges, ended by an accepted beat.
    task automatic stall_run(input int p, input int t, input int len, input string tag);
        int start;
        int n;
        start = ev_seen;
        n = (p + 1) * (t + 1);
        set_stall(p, t);
        if (len >= n) expect_after(n, tag);
        hold(len);
        strm_ready = 1'b1;
        hold(1);
        bus_idle();
        hold(3);
        check_count(start, (len >= n) ? 1 : 0, tag);
    endtask

    initial begin
        int start;
        rst_n = 1'b0;
        tmo_en = 1'b0;
        cfg_prescale = '0;
        cfg_limit = '0;
        bus_idle();
        hold(3);
        total++;
        if (tmo_event !== 1'b0) begin
            bad++;
            $display("FAIL R1: event %b during reset, expected 0", tmo_event);
        end
        rst_n = 1'b1;
        hold(5);
        check_count(0, 0, "R1");

        stall_run(0, 0, 3, "R9");
        stall_run(1, 2, 6, "R3");
        stall_run(3, 4, 25, "R3");
        stall_run(0, 1, 15, "R4");
        stall_run(2, 1, 5, "R3");

        // R5: a stall cut short by an accepted beat, then a fresh stall.
        start = ev_seen;
        set_stall(1, 2);
        hold(4);
        strm_ready = 1'b1;
        hold(1);
        strm_ready = 1'b0;
        expect_after(6, "R5");
        hold(8);
        bus_idle();
        hold(3);
        check_count(start, 1, "R5");

        // R8: a configuration change mid-count keeps the captured interval.
        start = ev_seen;
        set_stall(1, 2);
        expect_after(6, "R8");
        hold(2);
        cfg_prescale = 12'd0;
        cfg_limit = 12'd0;
        hold(8);
        strm_ready = 1'b1;
        hold(1);
        bus_idle();
        hold(3);
        check_count(start, 1, "R8");
        stall_run(0, 0, 3, "R8");

        // R2: pending drops for one cycle and discards the progress.
        start = ev_seen;
        set_stall(1, 2);
        hold(3);
        xfer_pending = 1'b0;
        hold(1);
        xfer_pending = 1'b1;
        expect_after(6, "R2");
        hold(7);
        bus_idle();
        hold(3);
        check_count(start, 1, "R2");

        // R6: enable cleared mid-stall, then a full stall with it clear.
        start = ev_seen;
        set_stall(1, 2);
        hold(5);
        tmo_en = 1'b0;
        hold(1);
        tmo_en = 1'b1;
        expect_after(6, "R6");
        hold(7);
        bus_idle();
        hold(3);
        check_count(start, 1, "R6");
        start = ev_seen;
        set_stall(0, 0);
        tmo_en = 1'b0;
        hold(30);
        bus_idle();
        hold(3);
        check_count(start, 0, "R6");

        // R7: no data left, stream refusing.
        start = ev_seen;
        set_stall(0, 0);
        xfer_pending = 1'b0;
        hold(30);
        bus_idle();
        hold(3);
        check_count(start, 0, "R7");

        // R10: no beat offered while the consumer is not ready.
        start = ev_seen;
        set_stall(0, 0);
        strm_valid = 1'b0;
        hold(30);
        bus_idle();
        hold(3);
        check_count(start, 0, "R10");

        hold(5);
        while (exp_cyc.size() != 0) begin
            int e;
            string t;
            e = exp_cyc.pop_front();
            t = exp_tag.pop_front();
            total++;
            bad++;
            $display("FAIL %s: no event seen, expected one at cycle %0d", t, e);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule